// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block moves a requested number of bytes between a local buffer and system memory. The memory side is described by a table of scatter-gather descriptors that the block reads from memory itself. Each descriptor is 8 bytes: a 32-bit little-endian region address followed by a 32-bit word that holds the region length and an end-of-table flag. A start pulse latches the table base, the direction and the byte count. The block then alternates between fetching a descriptor and moving data beats through that region. It stops when the count is met, when a region flagged as final runs out, or when it has read one full 4096-byte page of table.

All memory traffic goes over one request channel: valid/ready, a write flag, an address, write data and byte enables. Read data returns on a response strobe. Only one request is outstanding at a time, and every response is accepted in the cycle it arrives. Data moves in 32-bit beats. A beat carries 4 bytes, or 2 bytes (byte enables 0011) when fewer than 4 bytes are left in the count or in the region. No beat crosses a region boundary.

The buffer side is two valid/ready streams. The input stream supplies one word per memory write. The output stream delivers one word per memory read, with its byte enables. Back-pressure rules: the walker holds a memory request and its address stable until ready is seen. It holds output data stable until the output is accepted. It takes an input word only in the same cycle that the memory write is accepted. The requester must hold each offered input word until it is taken. When the walk ends, a one-cycle done pulse is raised. At the same time an incomplete flag is set if the table ended before the count was met. That flag holds until the next start.

Top module: `sg_walker`

## Requirements
- R1: While reset is held and right after it, done, incomplete, mem_req_valid, buf_out_valid and buf_in_ready are all 0.
- R2: Each descriptor is fetched as two 32-bit reads with all byte enables set. The first read is at the table pointer and the second at pointer+4. The first word is the region address and the second is the length and flags. The next descriptor is read 8 bytes further on.
- R3: The region length is the second word masked with 0xFFFE, so bit 0 has no effect. A masked value of 0 means a region of 65536 bytes.
- R4: If a region whose second word has bit 31 set runs out while bytes are still owed, the walk ends with a done pulse and incomplete = 1. No further descriptor is read.
- R5: No descriptor is fetched once the table pointer is 4096 or more bytes past the table base. In that case the walk ends with incomplete = 1, so at most 512 descriptors are read per walk.
- R6: A descriptor is fetched only when the current region has no bytes left and bytes are still owed. Bytes left over in a region when the count is met cause no further fetch.
- R7: Each data beat moves min(4, bytes still owed, bytes left in region) bytes at the current region address. Byte enables are 1111 for 4 bytes and 0011 for 2 bytes. The address then advances by the beat size.
- R8: With dir = 1, each buffer input word is written to memory as one beat with its data unchanged, in order.
- R9: With dir = 0, each beat is a memory read. The returned word appears on buf_out_data with the beat's byte enables, in order.
- R10: When the owed count reaches zero, done pulses for exactly one cycle with incomplete = 0. Bit 0 of req_bytes is ignored, so a count of 0 or 1 finishes with no memory traffic. Incomplete keeps its value until the next start.
- R11: A memory read request that is not accepted stays valid with an unchanged address. Output data that is not accepted stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| dir | input | 1 | 1: buffer to memory, 0: memory to buffer |
| tbl_base | input | ADDR_W | Descriptor table base address |
| req_bytes | input | CNT_W | Bytes to move (bit 0 ignored) |
| done | output | 1 | One-cycle end-of-walk pulse |
| incomplete | output | 1 | Table ended before the count was met |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1: write, 0: read |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte enables |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| buf_in_valid | input | 1 | Buffer input word valid |
| buf_in_ready | output | 1 | Buffer input word taken |
| buf_in_data | input | 32 | Buffer input word |
| buf_out_valid | output | 1 | Buffer output word valid |
| buf_out_ready | input | 1 | Buffer output word accepted |
| buf_out_data | output | 32 | Buffer output word |
| buf_out_be | output | 4 | Valid bytes of the output word |

## Verification
The page safety stop is the hardest case to reach from the ports. It needs 512 chained descriptors, none flagged final, plus a 513th descriptor flagged final that must never be read. The bench builds such a table of 2-byte regions in its memory model, asks for more bytes than the table can supply, and counts table reads. The 64 KiB meaning of a zero length is reached by a descriptor whose masked length is 0, followed by a short final region. The bench then checks that the first beat of the second region comes exactly after 16384 full beats.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int REGION_W = 17;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_DREQ,
    S_DWAIT,
    S_XFER,
    S_RWAIT,
    S_OUT
  } sgw_state_e;
endpackage

// File: rtl/sgw_len_decode.sv
module sgw_len_decode
  import sgw_pkg::*;
(
  input  logic [31:0]         flags_word,
  output logic [REGION_W-1:0] region_len,
  output logic                is_final
);
  logic [15:0] masked;
  logic        unused_bits;

  assign masked      = flags_word[15:0] & 16'hFFFE;
  assign region_len  = (masked == 16'd0) ? REGION_W'(65536) : REGION_W'(masked);
  assign is_final    = flags_word[31];
  assign unused_bits = ^flags_word[30:16];
endmodule

// File: rtl/sgw_beat_plan.sv
module sgw_beat_plan
  import sgw_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0]    owed,
  input  logic [REGION_W-1:0] region_left,
  output logic [2:0]          beat_bytes,
  output logic [3:0]          beat_be
);
  logic full_beat;

  assign full_beat  = (owed >= CNT_W'(4)) && (region_left >= REGION_W'(4));
  assign beat_bytes = full_beat ? 3'd4 : 3'd2;
  assign beat_be    = full_beat ? 4'hF : 4'h3;
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [CNT_W-1:0]  req_bytes,
  output logic              done,
  output logic              incomplete,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  output logic [3:0]        mem_req_be,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              buf_in_valid,
  output logic              buf_in_ready,
  input  logic [31:0]       buf_in_data,
  output logic              buf_out_valid,
  input  logic              buf_out_ready,
  output logic [31:0]       buf_out_data,
  output logic [3:0]        buf_out_be
);
  localparam logic [ADDR_W-1:0] PAGE_LIM = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  sgw_state_e          st;
  logic [ADDR_W-1:0]   base_q, ptr_q, raddr_q;
  logic [CNT_W-1:0]    owed_q;
  logic [REGION_W-1:0] left_q;
  logic                final_q, dir_q, second_word_q;
  logic [REGION_W-1:0] dec_len;
  logic                dec_final;
  logic [2:0]          bsz;
  logic [3:0]          bbe;
  logic                page_hit;
  logic                wr_fire;

  sgw_len_decode u_dec (
    .flags_word (mem_rsp_data),
    .region_len (dec_len),
    .is_final   (dec_final)
  );

  sgw_beat_plan #(.CNT_W(CNT_W)) u_plan (
    .owed        (owed_q),
    .region_left (left_q),
    .beat_bytes  (bsz),
    .beat_be     (bbe)
  );

  assign page_hit      = (ptr_q - base_q) >= PAGE_LIM;
  assign mem_req_valid = (st == S_DREQ) || ((st == S_XFER) && (!dir_q || buf_in_valid));
  assign mem_req_write = (st == S_XFER) && dir_q;
  assign mem_req_addr  = (st == S_DREQ) ? ptr_q : raddr_q;
  assign mem_req_be    = (st == S_XFER) ? bbe : 4'hF;
  assign mem_req_wdata = buf_in_data;
  assign buf_in_ready  = (st == S_XFER) && dir_q && mem_req_ready;
  assign wr_fire       = buf_in_ready && buf_in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      base_q        <= '0;
      ptr_q         <= '0;
      raddr_q       <= '0;
      owed_q        <= '0;
      left_q        <= '0;
      final_q       <= 1'b0;
      dir_q         <= 1'b0;
      second_word_q <= 1'b0;
      done          <= 1'b0;
      incomplete    <= 1'b0;
      buf_out_valid <= 1'b0;
      buf_out_data  <= '0;
      buf_out_be    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q        <= tbl_base;
          ptr_q         <= tbl_base;
          owed_q        <= {req_bytes[CNT_W-1:1], 1'b0};
          left_q        <= '0;
          final_q       <= 1'b0;
          second_word_q <= 1'b0;
          dir_q         <= dir;
          incomplete    <= 1'b0;
          st            <= S_CHECK;
        end
        S_CHECK: begin
          if (owed_q == '0) begin
            done       <= 1'b1;
            incomplete <= 1'b0;
            st         <= S_IDLE;
          end else if (left_q != '0) begin
            st <= S_XFER;
          end else if (final_q || page_hit) begin
            done       <= 1'b1;
            incomplete <= 1'b1;
            st         <= S_IDLE;
          end else begin
            st <= S_DREQ;
          end
        end
        S_DREQ: if (mem_req_ready) st <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          ptr_q <= ptr_q + WORD_STEP;
          if (!second_word_q) begin
            raddr_q       <= mem_rsp_data[ADDR_W-1:0];
            second_word_q <= 1'b1;
            st            <= S_DREQ;
          end else begin
            left_q        <= dec_len;
            final_q       <= dec_final;
            second_word_q <= 1'b0;
            st            <= S_CHECK;
          end
        end
        S_XFER: begin
          if (dir_q) begin
            if (wr_fire) begin
              raddr_q <= raddr_q + ADDR_W'(bsz);
              left_q  <= left_q - REGION_W'(bsz);
              owed_q  <= owed_q - CNT_W'(bsz);
              st      <= S_CHECK;
            end
          end else if (mem_req_ready) begin
            st <= S_RWAIT;
          end
        end
        S_RWAIT: if (mem_rsp_valid) begin
          buf_out_data  <= mem_rsp_data;
          buf_out_be    <= bbe;
          buf_out_valid <= 1'b1;
          st            <= S_OUT;
        end
        S_OUT: if (buf_out_ready) begin
          buf_out_valid <= 1'b0;
          raddr_q       <= raddr_q + ADDR_W'(bsz);
          left_q        <= left_q - REGION_W'(bsz);
          owed_q        <= owed_q - CNT_W'(bsz);
          st            <= S_CHECK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_out_valid && !buf_out_ready) |=> (buf_out_valid && $stable(buf_out_data) && $stable(buf_out_be))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FETCH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DREQ) |-> ((ptr_q - base_q) < (PAGE_LIM + WORD_STEP))); // R5
  AST_NO_FETCH_WITH_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DREQ) |-> (left_q == '0)); // R6
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_be == 4'hF) || (mem_req_be == 4'h3))); // R7
  AST_LEFT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q[0] == 1'b0) && (owed_q[0] == 1'b0)); // R3
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> ((st == S_DWAIT) || (st == S_RWAIT))); // R2
endmodule

// File: tb/sg_walker_test.sv
`timescale 1ns/1ps
module sg_walker_test;
  localparam logic [31:0] TBL_FLOOR = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [19:0] req_bytes = '0;
  logic        done, incomplete;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        buf_in_valid = 1'b0;
  logic        buf_in_ready;
  logic [31:0] buf_in_data = '0;
  logic        buf_out_valid;
  logic        buf_out_ready = 1'b0;
  logic [31:0] buf_out_data;
  logic [3:0]  buf_out_be;

  sg_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .tbl_base(tbl_base),
    .req_bytes(req_bytes), .done(done), .incomplete(incomplete),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .buf_in_valid(buf_in_valid), .buf_in_ready(buf_in_ready), .buf_in_data(buf_in_data),
    .buf_out_valid(buf_out_valid), .buf_out_ready(buf_out_ready),
    .buf_out_data(buf_out_data), .buf_out_be(buf_out_be)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] a;
    logic [3:0]  be;
    logic [31:0] d;
  } beat_t;

  beat_t       expq[$];
  beat_t       rdq[$];
  logic [31:0] srcq[$];
  logic [31:0] mem [logic [31:0]];
  int          tests = 0;
  int          errs = 0;
  int          cyc = 0;
  int          fwords = 0;
  logic [31:0] tbl_cur = '0;
  bit          dir_cur = 1'b0;
  bit          stall_on = 1'b0;
  logic        mrdy = 1'b0;

  assign mem_req_ready = mrdy;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: ready pattern, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mrdy          <= 1'b0;
      mem_rsp_valid <= 1'b0;
    end else begin
      mrdy          <= stall_on ? (cyc[1:0] != 2'd3) : 1'b1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          logic [31:0] w;
          w = mrd(mem_req_addr);
          for (int b = 0; b < 4; b++)
            if (mem_req_be[b]) w[8*b +: 8] = mem_req_wdata[8*b +: 8];
          mem[mem_req_addr] = w;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mrd(mem_req_addr);
        end
      end
    end
  end

  // buffer input source and buffer output sink
  always @(posedge clk) begin
    if (buf_in_valid && buf_in_ready) void'(srcq.pop_front());
    buf_in_valid  <= rst_n && (srcq.size() > 0);
    buf_in_data   <= (srcq.size() > 0) ? srcq[0] : 32'h0;
    buf_out_ready <= rst_n && ((cyc % 3) != 1);
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_addr >= TBL_FLOOR) begin
        chk(!mem_req_write && mem_req_be == 4'hF && mem_req_addr == tbl_cur + 32'(4 * fwords),
            "R2 fetch addr", {31'b0, mem_req_write, mem_req_addr}, {32'b0, tbl_cur + 32'(4 * fwords)});
        fwords++;
      end else if (expq.size() == 0) begin
        chk(1'b0, "R7 unexpected beat", {32'b0, mem_req_addr}, 64'h0);
      end else begin
        beat_t e;
        e = expq.pop_front();
        chk(mem_req_addr == e.a && mem_req_be == e.be && mem_req_write == dir_cur,
            "R7 beat addr/be", {28'b0, mem_req_be, mem_req_addr}, {28'b0, e.be, e.a});
        if (dir_cur) chk(mem_req_wdata == e.d, "R8 write data", {32'b0, mem_req_wdata}, {32'b0, e.d});
        else rdq.push_back(e);
      end
    end
    if (rst_n && buf_out_valid && buf_out_ready) begin
      if (rdq.size() == 0) begin
        chk(1'b0, "R9 unexpected output", {32'b0, buf_out_data}, 64'h0);
      end else begin
        beat_t e;
        e = rdq.pop_front();
        chk(buf_out_data == e.d && buf_out_be == e.be, "R9 read data",
            {28'b0, buf_out_be, buf_out_data}, {28'b0, e.be, e.d});
      end
    end
  end

  task automatic put_desc(input logic [31:0] tbl, input int idx, input logic [31:0] a, input logic [31:0] w1);
    mem[tbl + 32'(8 * idx)]     = a;
    mem[tbl + 32'(8 * idx) + 4] = w1;
  endtask

  // driver: model the walk, push expected beats, start, await done
  task automatic run(input logic [31:0] tbl, input int req, input bit d, input bit stall,
                     input string tag_end, input string tag_fetch);
    int          need, left, nf, b, seq, wait_cyc;
    logic [31:0] ptr, ra, w1, dat;
    bit          lst, inc;
    need = req & ~1; ptr = tbl; ra = '0; left = 0; nf = 0; lst = 0; inc = 0; seq = 0;
    while (1) begin
      if (need == 0) begin inc = 0; break; end
      if (left == 0) begin
        if (lst || (ptr - tbl) >= 32'd4096) begin inc = 1; break; end
        ra = mrd(ptr); w1 = mrd(ptr + 4); ptr += 8; nf++;
        left = ((w1 & 32'hFFFE) == 0) ? 65536 : int'(w1 & 32'hFFFE);
        lst = w1[31];
      end else begin
        b = (need >= 4 && left >= 4) ? 4 : 2;
        dat = ra ^ 32'h5A00_0000 ^ 32'(seq * 32'h0001_0003);
        seq++;
        if (d) srcq.push_back(dat);
        else mem[ra] = dat;
        expq.push_back('{ra, (b == 4) ? 4'hF : 4'h3, dat});
        ra += 32'(b); left -= b; need -= b;
      end
    end
    @(negedge clk);
    tbl_cur = tbl; fwords = 0; dir_cur = d; stall_on = stall;
    tbl_base = tbl; req_bytes = 20'(req); dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_cyc = 0;
    while (!done && wait_cyc < 100000) begin @(negedge clk); wait_cyc++; end
    chk(done == 1'b1, {tag_end, " done seen"}, {63'b0, done}, 64'h1);
    chk(incomplete == inc, {tag_end, " incomplete"}, {63'b0, incomplete}, {63'b0, inc});
    chk(fwords == 2 * nf, {tag_fetch, " fetch words"}, 64'(fwords), 64'(2 * nf));
    chk(expq.size() == 0 && rdq.size() == 0, {tag_end, " all beats moved"},
        64'(expq.size() + rdq.size()), 64'h0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", {63'b0, done}, 64'h0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    tests++; errs++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 0 && incomplete == 0 && mem_req_valid == 0 && buf_out_valid == 0 && buf_in_ready == 0,
        "R1 reset outputs", {59'b0, done, incomplete, mem_req_valid, buf_out_valid, buf_in_ready}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && incomplete == 0 && mem_req_valid == 0 && buf_out_valid == 0,
        "R1 after reset", {60'b0, done, incomplete, mem_req_valid, buf_out_valid}, 64'h0);

    // R8 R6: two regions, length bit 0 set on first, count met mid second region
    put_desc(32'h1000_0000, 0, 32'h0002_0000, 32'h0000_000B);
    put_desc(32'h1000_0000, 1, 32'h0003_0000, 32'h8000_0008);
    run(32'h1000_0000, 14, 1'b1, 1'b1, "R8 R10", "R6");

    // R4 R9: final region too short, read direction, throttled output
    put_desc(32'h1000_1000, 0, 32'h0004_0000, 32'h8000_000C);
    run(32'h1000_1000, 20, 1'b0, 1'b1, "R4", "R4 R9");

    // R10: incomplete held until next start
    chk(incomplete == 1'b1, "R10 incomplete held", {63'b0, incomplete}, 64'h1);

    // R6 R10: odd count with bit 0 ignored, region larger than count
    put_desc(32'h1000_2000, 0, 32'h0005_0000, 32'h0000_0010);
    put_desc(32'h1000_2000, 1, 32'h0006_0000, 32'h8000_0010);
    run(32'h1000_2000, 7, 1'b1, 1'b1, "R10", "R6");

    // R10: count of one means nothing to move
    run(32'h1000_3000, 1, 1'b0, 1'b0, "R10 zero count", "R10 zero count");

    // R3: masked length zero is a 64 KiB region
    put_desc(32'h1000_4000, 0, 32'h0010_0000, 32'h0000_0001);
    put_desc(32'h1000_4000, 1, 32'h0020_0000, 32'h8000_0006);
    run(32'h1000_4000, 65536 + 6, 1'b1, 1'b0, "R3", "R3");

    // R5: 512 non-final descriptors, 513th final must never be read
    for (int i = 0; i < 513; i++)
      put_desc(32'h1001_0000, i, 32'h0030_0000 + 32'(16 * i), (i == 512) ? 32'h8000_0002 : 32'h0000_0002);
    run(32'h1001_0000, 4000, 1'b0, 1'b0, "R5", "R5");

    $display("[TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  end
endmodule